// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a host request port and a multiplexed-address DRAM with extended-data-out page mode. The host offers one access at a time with a valid/ready handshake: a read or write flag, a row, a column and, for writes, a data nibble. The controller opens the row with RAS, presents the column and strobes CAS. It then either returns the read nibble with a one-cycle valid pulse or completes an early write. After the column finishes, the row stays open. Further requests to the same row run as short page-mode column cycles with RAS held low.

Every analog delay of the memory is a parameter counted in whole clock cycles. These include the RAS pulse and precharge, the CAS precharge, the page and random cycle times, the row-address hold, the RAS-to-CAS delay and the three read access times. Each strobe edge waits until every limit that applies to it has run out. A request to a different row, or a row held open past a controller limit, closes the row and waits out precharge before the next row opens. A separate refresh and initialisation agent claims the memory pins through a request/acknowledge pair. The controller hands them over only between column cycles, after it has closed the row.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is asserted and just after it, RAS, CAS, WE and OE (all active low) are 1, the data bus is not driven, rd_valid is 0 and gnt_ack is 0.
- R2: The row of the accepted request is on dram_addr when RAS falls and stays there for at least T_RAH cycles. The request's column is on dram_addr when CAS falls.
- R3: RAS stays low at least T_RAS cycles before it rises. RAS stays high at least T_RP cycles before it falls again. Successive RAS falls are at least T_RC cycles apart.
- R4: CAS falls only while RAS is low and at least T_RCD cycles after RAS fell. Before each fall, CAS has been high for at least T_CP cycles, and successive CAS falls are at least T_PC cycles apart.
- R5: For a read, WE is 1 and OE is 0. dram_dq_i is sampled only at an edge where at least T_RAC cycles have passed since RAS fell, T_CAC since CAS fell and T_AA since the column was presented. The sampled nibble appears on rd_data with a one-cycle rd_valid pulse, and reads return in request order.
- R6: For a write, WE is 0 and the write nibble is driven (dram_dq_oe = 1) on the edge before CAS falls. OE stays 1 whenever WE is 0 or the bus is driven.
- R7: A request to the row that is open is accepted without a new RAS fall and runs as a page-mode column cycle.
- R8: A request to a different row closes the open row (RAS rises once T_RAS is met), waits out precharge, and then opens the new row.
- R9: Once RAS has been low for T_ROW_MAX cycles, the row is closed at the next column boundary, even if requests keep hitting it.
- R10: When gnt_req is 1, new requests are refused. At the next column boundary the row is closed, and after precharge gnt_ack rises with RAS and CAS at 1 and req_ready at 0. gnt_ack falls one cycle after gnt_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | AW | Row address |
| req_col | input | AW | Column address |
| req_wdata | input | DW | Write nibble |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| rd_data | output | DW | Read nibble |
| gnt_req | input | 1 | Refresh agent asks for the memory pins |
| gnt_ack | output | 1 | Pins released to the refresh agent |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_o | output | DW | Write data to memory |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_i | input | DW | Data from memory |

## Verification
The bound checker watches the strobe relations on every cycle. It checks the minimum RAS low and high widths, the CAS precharge and the RAS-to-CAS delay, CAS staying inside RAS, the row-address hold, OE being high whenever WE is low or the bus is driven, a quiet bus while granted, and the single-cycle read strobe. Other behaviours can be shown only by the bench scenarios, whose memory model returns a corrupted nibble until every access time is met. These are data correctness, read ordering, the page-cycle and random-cycle spacing, the early-write ordering, hit versus miss behaviour counted in RAS falls, the forced close after the row-open limit, and the grant hand-over.

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int AW        = 11,
  parameter int DW        = 4,
  parameter int T_RAC     = 5,
  parameter int T_CAC     = 2,
  parameter int T_AA      = 3,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int T_CP      = 1,
  parameter int T_PC      = 2,
  parameter int T_RC      = 9,
  parameter int T_RAH     = 1,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 1,
  parameter int T_ROW_MAX = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_row,
  input  logic [AW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          gnt_req,
  output logic          gnt_ack,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  output logic [AW-1:0] dram_addr,
  output logic [DW-1:0] dram_dq_o,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_i
);

  localparam int CNW = $clog2(T_ROW_MAX + T_RC + T_RAC + T_AA + 4) + 1;
  localparam logic [CNW-1:0] SAT   = '1;
  localparam logic [CNW-1:0] ONE   = CNW'(1);
  localparam logic [CNW-1:0] C_RAC = CNW'(T_RAC);
  localparam logic [CNW-1:0] C_CAC = CNW'(T_CAC);
  localparam logic [CNW-1:0] C_AA  = CNW'(T_AA);
  localparam logic [CNW-1:0] C_RAS = CNW'(T_RAS);
  localparam logic [CNW-1:0] C_RP  = CNW'(T_RP);
  localparam logic [CNW-1:0] C_CP  = CNW'(T_CP);
  localparam logic [CNW-1:0] C_PC  = CNW'(T_PC);
  localparam logic [CNW-1:0] C_RC  = CNW'(T_RC);
  localparam logic [CNW-1:0] C_RAH = CNW'(T_RAH);
  localparam logic [CNW-1:0] C_RCD = CNW'(T_RCD);
  localparam logic [CNW-1:0] C_CAS = CNW'(T_CAS);
  localparam logic [CNW-1:0] C_MAX = CNW'(T_ROW_MAX);

  typedef enum logic [2:0] {S_IDLE, S_GNT, S_ROW, S_COL, S_CAS, S_OPEN} st_t;

  st_t           st;
  logic [AW-1:0] open_row, col_q;
  logic          wr_q;
  logic [CNW-1:0] ras_el, pre_el, cas_el, cp_el, col_el;

  function automatic logic [CNW-1:0] inc(input logic [CNW-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  wire row_hit   = (req_row == open_row);
  wire row_old   = (ras_el >= C_MAX);
  wire can_close = (ras_el >= C_RAS);
  wire can_open  = (pre_el >= C_RP) && (ras_el >= C_RC);
  wire cas_go    = (ras_el >= C_RCD) && (cp_el >= C_CP) && (cas_el >= C_PC);
  wire rd_ok     = (ras_el >= C_RAC) && (cas_el >= C_CAC) && (col_el >= C_AA) && (cas_el >= C_CAS);
  wire col_done  = wr_q ? (cas_el >= C_CAS) : rd_ok;
  wire want_close = gnt_req || row_old || (req_valid && !row_hit);

  assign req_ready = !gnt_req &&
                     ((st == S_IDLE && can_open) || (st == S_OPEN && row_hit && !row_old));
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_addr  <= '0;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      gnt_ack    <= 1'b0;
      open_row   <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      ras_el     <= SAT;
      pre_el     <= SAT;
      cas_el     <= SAT;
      cp_el      <= SAT;
      col_el     <= SAT;
    end else begin
      rd_valid <= 1'b0;
      ras_el   <= inc(ras_el);
      pre_el   <= inc(pre_el);
      cas_el   <= inc(cas_el);
      cp_el    <= inc(cp_el);
      col_el   <= inc(col_el);
      case (st)
        S_IDLE: begin
          if (gnt_req && pre_el >= C_RP) begin
            gnt_ack <= 1'b1;
            st      <= S_GNT;
          end else if (accept) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= req_row;
            open_row   <= req_row;
            col_q      <= req_col;
            wr_q       <= req_write;
            dram_dq_o  <= req_wdata;
            ras_el     <= ONE;
            st         <= S_ROW;
          end
        end
        S_GNT: begin
          if (!gnt_req) begin
            gnt_ack <= 1'b0;
            pre_el  <= ONE;
            st      <= S_IDLE;
          end
        end
        S_ROW: begin
          if (ras_el >= C_RAH) begin
            dram_addr  <= col_q;
            dram_we_n  <= !wr_q;
            dram_oe_n  <= wr_q;
            dram_dq_oe <= wr_q;
            col_el     <= ONE;
            st         <= S_COL;
          end
        end
        S_COL: begin
          if (cas_go) begin
            dram_cas_n <= 1'b0;
            cas_el     <= ONE;
            st         <= S_CAS;
          end
        end
        S_CAS: begin
          if (col_done) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            cp_el      <= ONE;
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_i;
            end
            st <= S_OPEN;
          end
        end
        S_OPEN: begin
          if (want_close) begin
            if (can_close) begin
              dram_ras_n <= 1'b1;
              pre_el     <= ONE;
              st         <= S_IDLE;
            end
          end else if (accept) begin
            col_q      <= req_col;
            wr_q       <= req_write;
            dram_dq_o  <= req_wdata;
            dram_addr  <= req_col;
            dram_we_n  <= !req_write;
            dram_oe_n  <= req_write;
            dram_dq_oe <= req_write;
            col_el     <= ONE;
            st         <= S_COL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int AW    = 11,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3,
  parameter int T_CP  = 1,
  parameter int T_RCD = 2,
  parameter int T_RAH = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr,
  input logic          gnt_ack,
  input logic          req_ready,
  input logic          rd_valid
);

  logic [15:0] lo_cnt, hi_cnt, chi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt  <= '0;
      hi_cnt  <= '1;
      chi_cnt <= '1;
    end else begin
      if (ras_n) begin
        lo_cnt <= '0;
        hi_cnt <= (hi_cnt == '1) ? hi_cnt : hi_cnt + 16'd1;
      end else begin
        hi_cnt <= '0;
        lo_cnt <= (lo_cnt == '1) ? lo_cnt : lo_cnt + 16'd1;
      end
      if (cas_n) chi_cnt <= (chi_cnt == '1) ? chi_cnt : chi_cnt + 16'd1;
      else       chi_cnt <= '0;
    end
  end

  a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n) && lo_cnt < 16'(T_RAH)) |-> $stable(addr));
  a_r3_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_cnt >= 16'(T_RAS));
  a_r3_ras_pre_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 16'(T_RP));
  a_r4_cas_pre_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> chi_cnt >= 16'(T_CP));
  a_r4_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> lo_cnt >= 16'(T_RCD));
  a_r4_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  a_r6_we_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  a_r6_drive_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  a_r10_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_ack |-> (ras_n && cas_n && !req_ready));
  a_r5_rdv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind edo_ctrl edo_ctrl_chk #(
  .AW(AW), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_RAH(T_RAH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .addr(dram_addr),
  .gnt_ack(gnt_ack), .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
  localparam int RAC = 5, CAC = 2, AA = 3, RAS = 5, RP = 3, CP = 1, PC = 2, RC = 9, RCD = 2;
  localparam int ROWMAX = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, gnt_req = 0;
  logic [10:0] req_row = 0, req_col = 0;
  logic [3:0] req_wdata = 0;
  logic req_ready, rd_valid, gnt_ack;
  logic [3:0] rd_data;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [10:0] addr;
  logic [3:0] dq_o, dq_i;

  always #2 clk = ~clk;

  edo_ctrl #(.T_ROW_MAX(ROWMAX)) u_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .gnt_req(gnt_req), .gnt_ack(gnt_ack),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(addr), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i));

  typedef struct packed { logic w; logic [10:0] row; logic [10:0] col; logic [3:0] d; logic [3:0] e; } cmd_t;
  cmd_t cmdq[$];
  logic [3:0] rdq[$];
  logic [3:0] mem [64];
  logic [3:0] refm[64];
  int n_chk = 0, n_fail = 0, ras_falls = 0;
  bit done = 0;

  int m_ras = 1000, m_rhi = 1000, m_cas = 1000, m_chi = 1000, m_col = 1000;
  logic [10:0] lat_row = 0, lat_col = 0, p_addr = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1;

  function automatic int idx(input logic [10:0] r, input logic [10:0] c);
    return {r[1:0], c[3:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  assign dq_i = (!oe_n && !cas_n && m_ras >= RAC && m_cas >= CAC && m_col >= AA)
                ? mem[idx(lat_row, lat_col)] : ~mem[idx(lat_row, lat_col)];

  always @(negedge clk) if (rst_n) begin
    if (!ras_n && p_ras) begin
      chk(m_rhi >= RP, "R3 precharge", m_rhi, RP);
      chk(m_ras >= RC, "R3 cycle time", m_ras, RC);
      m_ras = 1; lat_row = addr; ras_falls++;
    end else begin
      if (ras_n && !p_ras) chk(m_ras >= RAS, "R3 ras width", m_ras, RAS);
      m_ras++;
    end
    if (ras_n) m_rhi = (!p_ras) ? 1 : m_rhi + 1;
    if (addr != p_addr) m_col = 1; else m_col++;
    if (!cas_n && p_cas) begin
      cmd_t c;
      chk(m_chi >= CP, "R4 cas precharge", m_chi, CP);
      chk(m_cas >= PC, "R4 page cycle", m_cas, PC);
      chk(m_ras >= RCD, "R4 ras to cas", m_ras, RCD);
      m_cas = 1; lat_col = addr;
      chk(cmdq.size() > 0, "R2 column without request", 0, 1);
      if (cmdq.size() > 0) begin
        c = cmdq.pop_front();
        chk(lat_row == c.row, "R2 row address", lat_row, c.row);
        chk(addr == c.col, "R2 column address", addr, c.col);
        chk(we_n == !c.w, "R5 R6 write enable", we_n, !c.w);
        if (c.w) begin
          chk(!p_we && dq_oe && oe_n, "R6 early write order", {p_we, dq_oe, oe_n}, 3'b011);
          chk(dq_o == c.d, "R6 write data", dq_o, c.d);
          mem[idx(lat_row, lat_col)] = dq_o;
        end else begin
          chk(!oe_n, "R5 oe low on read", oe_n, 0);
          rdq.push_back(c.e);
        end
      end
    end else m_cas++;
    if (cas_n) m_chi = (!p_cas) ? 1 : m_chi + 1;
    if (rd_valid) begin
      chk(rdq.size() > 0, "R5 unexpected read strobe", 0, 1);
      if (rdq.size() > 0) begin
        logic [3:0] e;
        e = rdq.pop_front();
        chk(rd_data == e, "R5 read data", rd_data, e);
      end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr;
  end

  task automatic send(input logic w, input logic [10:0] row, input logic [10:0] col, input logic [3:0] d);
    cmd_t c;
    req_valid = 1; req_write = w; req_row = row; req_col = col; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (!ras_n) chk(row == lat_row, "R7 hit accepted on open row", row, lat_row);
    c.w = w; c.row = row; c.col = col; c.d = d; c.e = refm[idx(row, col)];
    if (w) refm[idx(row, col)] = d;
    cmdq.push_back(c);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 300 && (cmdq.size() != 0 || rdq.size() != 0); k++) @(negedge clk);
    chk(cmdq.size() == 0 && rdq.size() == 0, "R5 all requests completed", cmdq.size() + rdq.size(), 0);
  endtask

  task automatic grant_cycle();
    int k;
    @(negedge clk);
    gnt_req = 1;
    k = 0;
    while (!gnt_ack && k < 200) begin @(negedge clk); k++; end
    chk(gnt_ack && ras_n && cas_n, "R10 pins released closed", {gnt_ack, ras_n, cas_n}, 3'b111);
    req_valid = 1; req_row = 0; req_col = 0; req_write = 0;
    for (int j = 0; j < 4; j++) begin
      #1;
      chk(!req_ready && gnt_ack, "R10 requests refused while granted", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;
    gnt_req = 0;
    @(negedge clk);
    chk(!gnt_ack, "R10 ack released", gnt_ack, 0);
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up();
    end
  end

  initial begin
    int f0;
    logic [10:0] last_row;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin mem[i] = 4'(i * 7 + 3); refm[i] = 4'(i * 7 + 3); end
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && !gnt_ack,
        "R1 reset state", {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, gnt_ack}, 7'b1111000);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && !gnt_ack,
        "R1 after reset", {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, gnt_ack}, 7'b1111000);

    send(1, 11'd1, 11'd5, 4'h9);
    send(0, 11'd1, 11'd5, 4'h0);
    drain();
    f0 = ras_falls;
    send(0, 11'd2, 11'd1, 0);
    send(0, 11'd2, 11'd2, 0);
    send(1, 11'd2, 11'd3, 4'h6);
    send(0, 11'd2, 11'd3, 0);
    drain();
    chk(ras_falls - f0 == 1, "R7 page hits share one row open", ras_falls - f0, 1);
    f0 = ras_falls;
    send(0, 11'd3, 11'd0, 0);
    drain();
    chk(ras_falls - f0 == 1 && ras_n == 0, "R8 miss reopens new row", ras_falls - f0, 1);
    f0 = ras_falls;
    for (int i = 0; i < 20; i++) send(0, 11'd3, 11'(i % 16), 0);
    drain();
    chk(ras_falls - f0 >= 1, "R9 long open row closed", ras_falls - f0, 1);
    grant_cycle();
    send(0, 11'd3, 11'd0, 0);
    drain();

    last_row = 0;
    for (int i = 0; i < 300; i++) begin
      logic [10:0] r;
      r = ($urandom % 4 == 0) ? 11'($urandom % 4) : last_row;
      last_row = r;
      send(1'($urandom % 2), r, 11'($urandom % 16), 4'($urandom));
      if (i % 60 == 30) grant_cycle();
    end
    drain();
    done = 1;
    finish_up();
  end
endmodule